// File: doc/BRIEF.md
# Record Framing Timeout Checker

This block watches the framing of each tape record as it is read or written and reports two timing faults. The start-read check arms when the phase-lock indication rises and expects the preamble-found signal before a number of bit cells has passed. The end-data check arms when the end-of-postamble indication rises and expects the inter-record gap signal before its own number of bit cells has passed. Only the cycles that carry the bit-cell strobe advance either count.

Each limit is picked from a four-entry table that the recording density (high or medium) and the write/read direction select. Both results are active-low "good" flags. A fault clears a flag to 0, and the flag stays at 0 until the machine-cycle enable drops. With both density inputs low (the lowest density), neither check runs.

Top module: `tape_frame_timeout`

## Requirements
- R1: Start-read limits in bit-cell strobes: high density write 120, high density read 168, medium density write 52, medium density read 63.
- R2: The start-read count arms on the rising edge of `phase_ok`. When the limit-th strobe arrives and `pre_det` is still low, `srd_ok` becomes 0 after that clock edge. If `pre_det` rises earlier, the count stops with no fault. Cycles without `cell_tick` do not advance the count.
- R3: End-data limits in bit-cell strobes: high density write 88, high density read 248, medium density write 20, medium density read 36.
- R4: The end-data count arms on the rising edge of `post_end`. When the limit-th strobe arrives and `gap_det` is still low, `edc_ok` becomes 0 after that clock edge. If `gap_det` rises earlier, the count stops with no fault.
- R5: Once a flag is 0, it stays 0 while `cyc_en` is high. A late awaited signal and a new trigger do not change this.
- R6: While `cyc_en` is low, both flags read 1 in the same cycle. Both flags are 1 after reset.
- R7: With `dens_hi` = 0 and `dens_mid` = 0, neither check arms and neither flag falls.
- R8: When `dens_hi` and `dens_mid` are both 1, the high-density limits apply. `wr_mode` = 1 selects write and 0 selects read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_tick | input | 1 | One-cycle bit-cell strobe |
| dens_hi | input | 1 | High density selected |
| dens_mid | input | 1 | Medium density selected |
| wr_mode | input | 1 | 1 = write, 0 = read |
| cyc_en | input | 1 | Machine-cycle enable |
| phase_ok | input | 1 | Phase lock achieved, start-read trigger |
| pre_det | input | 1 | Preamble found |
| post_end | input | 1 | End of postamble, end-data trigger |
| gap_det | input | 1 | Inter-record gap found |
| srd_ok | output | 1 | Active-low start-read fault flag (1 = good) |
| edc_ok | output | 1 | Active-low end-data fault flag (1 = good) |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and the nominal table limits. With these limits every table entry can be reached in a few hundred strobes. For each of the eight mode and check pairs, the bench places the awaited signal one strobe before the limit and, separately, omits it through the limit, so that an off-by-one in either direction shows up. The 8-bit counter holds the largest limit, 248, with room to spare, and the bench also covers the lowest density and the case with both density bits set.

// File: rtl/tape_frame_timeout.sv
module tape_frame_timeout #(
  parameter int CW    = 8,
  parameter int SR_HW = 120,
  parameter int SR_HR = 168,
  parameter int SR_MW = 52,
  parameter int SR_MR = 63,
  parameter int ED_HW = 88,
  parameter int ED_HR = 248,
  parameter int ED_MW = 20,
  parameter int ED_MR = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_tick,
  input  logic dens_hi,
  input  logic dens_mid,
  input  logic wr_mode,
  input  logic cyc_en,
  input  logic phase_ok,
  input  logic pre_det,
  input  logic post_end,
  input  logic gap_det,
  output logic srd_ok,
  output logic edc_ok
);
  logic          ph_q, pe_q;
  logic          sr_arm, ed_arm;
  logic [CW-1:0] sr_cnt, ed_cnt;
  logic          sr_err, ed_err;
  logic [CW-1:0] sr_lim, ed_lim;
  logic          active, sr_exp, ed_exp;

  assign active = cyc_en & (dens_hi | dens_mid);

  assign sr_lim = dens_hi ? (wr_mode ? CW'(SR_HW) : CW'(SR_HR))
                          : (wr_mode ? CW'(SR_MW) : CW'(SR_MR));
  assign ed_lim = dens_hi ? (wr_mode ? CW'(ED_HW) : CW'(ED_HR))
                          : (wr_mode ? CW'(ED_MW) : CW'(ED_MR));

  assign sr_exp = sr_arm & cell_tick & (sr_cnt == sr_lim - 1'b1);
  assign ed_exp = ed_arm & cell_tick & (ed_cnt == ed_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      pe_q   <= 1'b0;
      sr_arm <= 1'b0;
      ed_arm <= 1'b0;
      sr_cnt <= '0;
      ed_cnt <= '0;
      sr_err <= 1'b0;
      ed_err <= 1'b0;
    end else begin
      ph_q <= phase_ok;
      pe_q <= post_end;

      if (!active) begin
        sr_arm <= 1'b0;
        sr_cnt <= '0;
      end else if (phase_ok & ~ph_q) begin
        sr_arm <= 1'b1;
        sr_cnt <= '0;
      end else if (sr_arm & (pre_det | sr_exp)) begin
        sr_arm <= 1'b0;
      end else if (sr_arm & cell_tick) begin
        sr_cnt <= sr_cnt + 1'b1;
      end

      if (!active) begin
        ed_arm <= 1'b0;
        ed_cnt <= '0;
      end else if (post_end & ~pe_q) begin
        ed_arm <= 1'b1;
        ed_cnt <= '0;
      end else if (ed_arm & (gap_det | ed_exp)) begin
        ed_arm <= 1'b0;
      end else if (ed_arm & cell_tick) begin
        ed_cnt <= ed_cnt + 1'b1;
      end

      if (!cyc_en)                         sr_err <= 1'b0;
      else if (active & sr_exp & ~pre_det) sr_err <= 1'b1;

      if (!cyc_en)                         ed_err <= 1'b0;
      else if (active & ed_exp & ~gap_det) ed_err <= 1'b1;
    end
  end

  assign srd_ok = ~(cyc_en & sr_err);
  assign edc_ok = ~(cyc_en & ed_err);
endmodule

// File: rtl/tape_frame_timeout_chk.sv
module tape_frame_timeout_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_tick,
  input logic dens_hi,
  input logic dens_mid,
  input logic cyc_en,
  input logic pre_det,
  input logic gap_det,
  input logic srd_ok,
  input logic edc_ok
);
  assert_idle_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |-> (srd_ok && edc_ok));

  assert_sticky_sr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !srd_ok) |=> (!cyc_en || !srd_ok));

  assert_sticky_ed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !edc_ok) |=> (!cyc_en || !edc_ok));

  assert_sr_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srd_ok) |-> ($past(cell_tick) && !$past(pre_det)));

  assert_ed_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edc_ok) |-> ($past(cell_tick) && !$past(gap_det)));

  assert_no_low_density_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(srd_ok) || $fell(edc_ok)) |-> $past(dens_hi || dens_mid));
endmodule

bind tape_frame_timeout tape_frame_timeout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .dens_hi(dens_hi),
  .dens_mid(dens_mid), .cyc_en(cyc_en), .pre_det(pre_det), .gap_det(gap_det),
  .srd_ok(srd_ok), .edc_ok(edc_ok)
);

// File: tb/sim_tape_frame_timeout.sv
module sim_tape_frame_timeout;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  // {chk(0=start-read,1=end-data), hi, mid, wr, arrive, 2'b0, n[8:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,1'b1,1'b1,2'b0,9'd119}, {1'b0,1'b1,1'b0,1'b1,1'b0,2'b0,9'd120},
    {1'b0,1'b1,1'b0,1'b0,1'b1,2'b0,9'd167}, {1'b0,1'b1,1'b0,1'b0,1'b0,2'b0,9'd168},
    {1'b0,1'b0,1'b1,1'b1,1'b1,2'b0,9'd51},  {1'b0,1'b0,1'b1,1'b1,1'b0,2'b0,9'd52},
    {1'b0,1'b0,1'b1,1'b0,1'b1,2'b0,9'd62},  {1'b0,1'b0,1'b1,1'b0,1'b0,2'b0,9'd63},
    {1'b1,1'b1,1'b0,1'b1,1'b1,2'b0,9'd87},  {1'b1,1'b1,1'b0,1'b1,1'b0,2'b0,9'd88},
    {1'b1,1'b1,1'b0,1'b0,1'b1,2'b0,9'd247}, {1'b1,1'b1,1'b0,1'b0,1'b0,2'b0,9'd248},
    {1'b1,1'b0,1'b1,1'b1,1'b1,2'b0,9'd19},  {1'b1,1'b0,1'b1,1'b1,1'b0,2'b0,9'd20},
    {1'b1,1'b0,1'b1,1'b0,1'b1,2'b0,9'd35},  {1'b1,1'b0,1'b1,1'b0,1'b0,2'b0,9'd36},
    {1'b0,1'b0,1'b0,1'b0,1'b0,2'b0,9'd300}, {1'b1,1'b0,1'b0,1'b1,1'b0,2'b0,9'd300},
    {1'b0,1'b1,1'b1,1'b0,1'b0,2'b0,9'd168}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cell_tick = 0, dens_hi = 0, dens_mid = 0, wr_mode = 0, cyc_en = 0;
  logic phase_ok = 0, pre_det = 0, post_end = 0, gap_det = 0;
  logic srd_ok, edc_ok;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tape_frame_timeout u0 (
    .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .dens_hi(dens_hi),
    .dens_mid(dens_mid), .wr_mode(wr_mode), .cyc_en(cyc_en), .phase_ok(phase_ok),
    .pre_det(pre_det), .post_end(post_end), .gap_det(gap_det),
    .srd_ok(srd_ok), .edc_ok(edc_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lim(input bit chk, input bit hi, input bit mid, input bit wr);
    if (!hi && !mid) return 100000;
    if (!chk) return hi ? (wr ? 120 : 168) : (wr ? 52 : 63);
    return hi ? (wr ? 88 : 248) : (wr ? 20 : 36);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cell_tick = 1;
      @(negedge clk) cell_tick = 0;
    end
  endtask

  task automatic cycle_off();
    @(negedge clk);
    phase_ok = 0; post_end = 0; pre_det = 0; gap_det = 0; cyc_en = 0;
    @(negedge clk) cyc_en = 1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset srd", srd_ok, 1'b1);
    check("R6 reset edc", edc_ok, 1'b1);
    rst_n = 1;
    @(negedge clk) cyc_en = 1;

    for (int v = 0; v < NV; v++) begin
      logic chk, arr; int n; logic exp_ok; string tag;
      chk = VEC[v][15]; arr = VEC[v][11]; n = int'(VEC[v][8:0]);
      cycle_off();
      dens_hi = VEC[v][14]; dens_mid = VEC[v][13]; wr_mode = VEC[v][12];
      exp_ok = !(n >= lim(chk, dens_hi, dens_mid, wr_mode));
      if (!dens_hi && !dens_mid) tag = "R7";
      else if (dens_hi && dens_mid) tag = "R8";
      else tag = chk ? "R3/R4" : "R1/R2";
      @(negedge clk) if (chk) post_end = 1; else phase_ok = 1;
      @(negedge clk);
      ticks(n);
      if (arr) begin
        if (chk) gap_det = 1; else pre_det = 1;
      end
      ticks(3);
      @(negedge clk);
      if (chk) begin
        check(tag, edc_ok, exp_ok);
        check({tag, " other flag"}, srd_ok, 1'b1);
      end else begin
        check(tag, srd_ok, exp_ok);
        check({tag, " other flag"}, edc_ok, 1'b1);
      end
    end

    // R2: idle cycles without strobes do not advance the count
    cycle_off();
    dens_hi = 0; dens_mid = 1; wr_mode = 1;
    @(negedge clk) phase_ok = 1;
    repeat (300) @(negedge clk);
    check("R2 no strobe", srd_ok, 1'b1);
    ticks(51);
    check("R2 51 strobes", srd_ok, 1'b1);
    ticks(1);
    check("R2 52nd strobe", srd_ok, 1'b0);

    // R5: late preamble and new trigger leave the fault in place
    pre_det = 1;
    ticks(2);
    phase_ok = 0;
    @(negedge clk) phase_ok = 1;
    ticks(5);
    check("R5 sticky srd", srd_ok, 1'b0);

    // R6: flag reads 1 as soon as cyc_en drops
    cyc_en = 0;
    #1 check("R6 cyc_en off", srd_ok, 1'b1);
    @(negedge clk) cyc_en = 1;
    @(negedge clk) check("R6 cyc_en back", srd_ok, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule